// File: doc/BRIEF.md
# SPI Serial Flash Command Responder

This block is a synthesizable SPI target, clock mode 0, that answers like a small serial flash device. It is meant to sit on the far side of a host SPI controller in a test system, so that the controller's command sequences can be tested against a target that really stores data. Each chip-select frame carries one opcode byte, then whatever address, dummy, data or response bytes that opcode needs. The data lives in an on-chip byte array.

The serial pins are oversampled by the system clock through a parameterised synchroniser. A byte-level command engine decodes each frame and keeps the status state: the busy flag, the write-enable latch and four protection bits. A single walker circuit fills a sector with FFh, and it also clears the whole array after reset. Protection is on at power-up. The host must send either the status-write enable opcode or the write-enable opcode, then write zero to the protection field, before it can program or erase. Busy time is modelled by a counter that is loaded when a program or erase frame closes.

Top module: `spi_flash_responder`

## Requirements
- R1: SPI mode 0. Bits are taken MSB first on the rising SCLK edge. The target changes spi_miso only after a falling SCLK edge. spi_miso is 0 while spi_cs_n is high.
- R2: Opcode 05h returns the status byte in every byte slot after the opcode. Bit 0 is busy, bit 1 is the write-enable latch and bits 5:2 are the protection field. Bits 7:6 read 0. After power-up and the initial fill, the status is 3Ch.
- R3: Opcode 06h sets the write-enable latch. Opcode 04h clears it.
- R4: While any protection bit is set, program and erase leave the array unchanged. Opcode 01h with one data byte copies data bits 5:2 into the protection field and clears the latch, but only if the opcode 06h or 50h came first. Without that, 01h is ignored.
- R5: Opcode 03h takes a 24-bit address, MSB first, and returns data from the next byte onward. The address increments after each byte and wraps modulo the array size of 4096 bytes.
- R6: Opcode 0Bh works like 03h, but one dummy byte comes between the address and the first data byte.
- R7: Opcode 9Fh returns the three identity bytes from the JEDEC_ID parameter, most significant first, then 00h.
- R8: Opcode 02h takes a 24-bit address and then data bytes. Each data byte is ANDed into the array. The address wraps inside its 256-byte page. If the latch is clear, nothing is written.
- R9: When the chip select rises on a program frame, the latch clears. If at least one byte was written, busy stays set for BUSY_CYCLES clocks.
- R10: The erase opcode (parameter, 20h by default) takes a 24-bit address. When the chip select rises, it fills the 4 KB sector holding that address with FFh and holds busy until the fill ends. It needs the latch to be set and clears the latch.
- R11: While busy is set, every opcode except 05h is ignored for the whole frame.
- R12: After reset every byte reads FFh. Busy reads 1 while this initial fill runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select that frames one command |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
The bench holds each SCLK level for six system clocks. A falling edge reaches spi_miso about SYNC_STAGES+1 clocks later. The bench therefore samples spi_miso on the clock just before it raises SCLK, well after the new bit has settled. Effects that happen when the chip select rises (the latch clearing, busy being loaded, the erase fill starting) land a few clocks after the rise. The bench leaves a 12-clock gap between frames, so the first status read after a program or erase must still show busy. Completion is then found by polling the status byte, and the reference model is used to predict every byte returned.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;
   localparam logic [7:0] OP_WRSR = 8'h01;
   localparam logic [7:0] OP_PGM  = 8'h02;
   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_WRDI = 8'h04;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_FAST = 8'h0B;
   localparam logic [7:0] OP_EWSR = 8'h50;
   localparam logic [7:0] OP_JID  = 8'h9F;

   typedef enum logic [3:0] {
      C_NONE, C_IGN, C_RDSR, C_READ, C_FAST, C_JID, C_PGM, C_ERASE, C_WRSR
   } cmd_e;
endpackage

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sclk,
   input  logic       spi_cs_n,
   input  logic       spi_mosi,
   output logic       spi_miso,
   output logic       frame_start,
   output logic       frame_end,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   input  logic [7:0] tx_byte
);
   logic [2:0] raw, s;
   assign raw = {spi_sclk, spi_cs_n, spi_mosi};

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign s = raw;
      end else begin : g_sync
         logic [2:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 3'b010;
            end else begin
               stg[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign s = stg[SYNC_STAGES-1];
      end
   endgenerate

   logic       sclk_q, cs_q, miso_q;
   logic [2:0] bit_cnt;
   logic [6:0] shreg, txsh;
   logic       rise, fall;

   assign rise        = s[2] & ~sclk_q & ~s[1];
   assign fall        = ~s[2] & sclk_q & ~s[1];
   assign frame_start = ~s[1] & cs_q;
   assign frame_end   = s[1] & ~cs_q;
   assign byte_done   = rise && (bit_cnt == 3'd7);
   assign rx_byte     = {shreg, s[0]};
   assign spi_miso    = miso_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         cs_q    <= 1'b1;
         miso_q  <= 1'b0;
         bit_cnt <= '0;
         shreg   <= '0;
         txsh    <= '0;
      end else begin
         sclk_q <= s[2];
         cs_q   <= s[1];
         if (s[1]) begin
            bit_cnt <= '0;
            miso_q  <= 1'b0;
         end else begin
            if (rise) begin
               shreg   <= {shreg[5:0], s[0]};
               bit_cnt <= bit_cnt + 3'd1;
            end
            if (fall) begin
               if (bit_cnt == 3'd0) {miso_q, txsh} <= tx_byte;
               else                 {miso_q, txsh} <= {txsh, 1'b0};
            end
         end
      end
   end

   AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q && s[1]) |-> !spi_miso); // R1
endmodule

// File: rtl/flash_store.sv
module flash_store #(
   parameter int MEM_BYTES = 4096,
   localparam int ADDR_W = $clog2(MEM_BYTES)
) (
   input  logic              clk,
   input  logic              we,
   input  logic              and_mode,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   logic [7:0] mem [MEM_BYTES];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= and_mode ? (mem[waddr] & wdata) : wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/flash_cmd_core.sv
module flash_cmd_core
   import spi_flash_pkg::*;
#(
   parameter int          MEM_BYTES    = 4096,
   parameter int          SECTOR_BYTES = 4096,
   parameter int          PAGE_BYTES   = 256,
   parameter int          BUSY_CYCLES  = 64,
   parameter logic [7:0]  ERASE_OP     = 8'h20,
   parameter logic [23:0] JEDEC_ID     = 24'hA5400C,
   localparam int ADDR_W = $clog2(MEM_BYTES),
   localparam int PAGE_W = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              byte_done,
   input  logic [7:0]        rx_byte,
   output logic [7:0]        tx_byte,
   output logic              mem_we,
   output logic              mem_and,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [7:0]        mem_wdata,
   output logic [ADDR_W-1:0] mem_raddr,
   input  logic [7:0]        mem_rdata
);
   localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);
   localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'(SECTOR_BYTES - 1);

   cmd_e              cmd;
   logic [2:0]        idx;
   logic [ADDR_W-1:0] cur_addr, ers_ptr, ers_last;
   logic              wel, ewsr, wrsr_ok, ers_on, pgm_hit;
   logic [3:0]        prot;
   logic [BCNT_W-1:0] bcnt;
   logic              busy, unprot, pgm_wr;
   logic [7:0]        status;

   assign busy   = (bcnt != '0) | ers_on;
   assign unprot = (prot == 4'h0);
   assign status = {2'b00, prot, wel, busy};
   assign pgm_wr = byte_done && (cmd == C_PGM) && (idx >= 3'd4) && wel && unprot;

   assign mem_we    = ers_on | pgm_wr;
   assign mem_and   = ~ers_on;
   assign mem_waddr = ers_on ? ers_ptr : cur_addr;
   assign mem_wdata = ers_on ? 8'hFF : rx_byte;
   assign mem_raddr = cur_addr;

   always_comb begin
      tx_byte = 8'h00;
      unique case (cmd)
         C_RDSR: tx_byte = status;
         C_JID: begin
            if (idx == 3'd1)      tx_byte = JEDEC_ID[23:16];
            else if (idx == 3'd2) tx_byte = JEDEC_ID[15:8];
            else if (idx == 3'd3) tx_byte = JEDEC_ID[7:0];
         end
         C_READ: if (idx >= 3'd4) tx_byte = mem_rdata;
         C_FAST: if (idx >= 3'd5) tx_byte = mem_rdata;
         default: tx_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd      <= C_NONE;
         idx      <= '0;
         cur_addr <= '0;
         wel      <= 1'b0;
         ewsr     <= 1'b0;
         wrsr_ok  <= 1'b0;
         prot     <= 4'hF;
         bcnt     <= '0;
         ers_on   <= 1'b1;
         ers_ptr  <= '0;
         ers_last <= '1;
         pgm_hit  <= 1'b0;
      end else begin
         if (ers_on) begin
            ers_ptr <= ers_ptr + ADDR_W'(1);
            if (ers_ptr == ers_last) ers_on <= 1'b0;
         end
         if (bcnt != '0) bcnt <= bcnt - BCNT_W'(1);

         if (frame_start) begin
            cmd     <= C_NONE;
            idx     <= '0;
            pgm_hit <= 1'b0;
         end

         if (byte_done) begin
            if (idx != 3'd7) idx <= idx + 3'd1;
            if (idx == 3'd0) begin
               if (busy && rx_byte != OP_RDSR) begin
                  cmd <= C_IGN;
               end else begin
                  ewsr <= (rx_byte == OP_EWSR);
                  cmd  <= C_NONE;
                  if (rx_byte == ERASE_OP) begin
                     cmd <= C_ERASE;
                  end else begin
                     case (rx_byte)
                        OP_RDSR: cmd <= C_RDSR;
                        OP_READ: cmd <= C_READ;
                        OP_FAST: cmd <= C_FAST;
                        OP_JID:  cmd <= C_JID;
                        OP_PGM:  cmd <= C_PGM;
                        OP_WRSR: begin
                           cmd     <= C_WRSR;
                           wrsr_ok <= wel | ewsr;
                        end
                        OP_WREN: wel <= 1'b1;
                        OP_WRDI: wel <= 1'b0;
                        default: cmd <= C_NONE;
                     endcase
                  end
               end
            end else begin
               if (idx <= 3'd3 && (cmd inside {C_READ, C_FAST, C_PGM, C_ERASE}))
                  cur_addr <= ADDR_W'({cur_addr, rx_byte});
               case (cmd)
                  C_WRSR: if (idx == 3'd1 && wrsr_ok) begin
                     prot <= rx_byte[5:2];
                     wel  <= 1'b0;
                  end
                  C_READ: if (idx >= 3'd4) cur_addr <= cur_addr + ADDR_W'(1);
                  C_FAST: if (idx >= 3'd5) cur_addr <= cur_addr + ADDR_W'(1);
                  C_PGM: if (pgm_wr) begin
                     cur_addr <= {cur_addr[ADDR_W-1:PAGE_W],
                                  cur_addr[PAGE_W-1:0] + PAGE_W'(1)};
                     pgm_hit  <= 1'b1;
                  end
                  default: ;
               endcase
            end
         end

         if (frame_end) begin
            case (cmd)
               C_PGM: begin
                  wel <= 1'b0;
                  if (pgm_hit) bcnt <= BCNT_W'(BUSY_CYCLES);
               end
               C_ERASE: if (idx >= 3'd4) begin
                  wel <= 1'b0;
                  if (wel && unprot) begin
                     ers_on   <= 1'b1;
                     ers_ptr  <= cur_addr & ~SECT_MASK;
                     ers_last <= cur_addr | SECT_MASK;
                     bcnt     <= BCNT_W'(BUSY_CYCLES);
                  end
               end
               default: ;
            endcase
            cmd <= C_NONE;
         end
      end
   end

   AST_LOCKED_NO_PGM: assert property (@(posedge clk) disable iff (!rst_n)
      (prot != 4'h0) |-> !(mem_we && mem_and)); // R4
   AST_PGM_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && cmd == C_PGM) |=> !wel); // R9
   AST_BUSY_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && byte_done && idx == 3'd0 && !wel) |=> !wel); // R11
   AST_BUSY_FREEZES_PROT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(prot)); // R11
endmodule

// File: rtl/spi_flash_responder.sv
module spi_flash_responder #(
   parameter int          MEM_BYTES    = 4096,
   parameter int          SECTOR_BYTES = 4096,
   parameter int          PAGE_BYTES   = 256,
   parameter int          BUSY_CYCLES  = 64,
   parameter int          SYNC_STAGES  = 2,
   parameter logic [7:0]  ERASE_OP     = 8'h20,
   parameter logic [23:0] JEDEC_ID     = 24'hA5400C
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sclk,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso
);
   localparam int ADDR_W = $clog2(MEM_BYTES);

   generate
      if ((1 << ADDR_W) != MEM_BYTES || MEM_BYTES < 512 || MEM_BYTES > (1 << 24)) begin : g_bad_mem
         $error("MEM_BYTES must be a power of two between 512 and 16M");
      end
      if ((1 << $clog2(SECTOR_BYTES)) != SECTOR_BYTES || SECTOR_BYTES > MEM_BYTES) begin : g_bad_sect
         $error("SECTOR_BYTES must be a power of two not above MEM_BYTES");
      end
      if ((1 << $clog2(PAGE_BYTES)) != PAGE_BYTES || PAGE_BYTES < 2 || PAGE_BYTES >= MEM_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two below MEM_BYTES");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
      if (ERASE_OP inside {8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0B, 8'h50, 8'h9F}) begin : g_bad_op
         $error("ERASE_OP collides with a fixed opcode");
      end
   endgenerate

   logic              frame_start, frame_end, byte_done;
   logic [7:0]        rx_byte, tx_byte;
   logic              mem_we, mem_and;
   logic [ADDR_W-1:0] mem_waddr, mem_raddr;
   logic [7:0]        mem_wdata, mem_rdata;

   spi_tgt_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_sclk   (spi_sclk),
      .spi_cs_n   (spi_cs_n),
      .spi_mosi   (spi_mosi),
      .spi_miso   (spi_miso),
      .frame_start(frame_start),
      .frame_end  (frame_end),
      .byte_done  (byte_done),
      .rx_byte    (rx_byte),
      .tx_byte    (tx_byte)
   );

   flash_cmd_core #(
      .MEM_BYTES   (MEM_BYTES),
      .SECTOR_BYTES(SECTOR_BYTES),
      .PAGE_BYTES  (PAGE_BYTES),
      .BUSY_CYCLES (BUSY_CYCLES),
      .ERASE_OP    (ERASE_OP),
      .JEDEC_ID    (JEDEC_ID)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .frame_end  (frame_end),
      .byte_done  (byte_done),
      .rx_byte    (rx_byte),
      .tx_byte    (tx_byte),
      .mem_we     (mem_we),
      .mem_and    (mem_and),
      .mem_waddr  (mem_waddr),
      .mem_wdata  (mem_wdata),
      .mem_raddr  (mem_raddr),
      .mem_rdata  (mem_rdata)
   );

   flash_store #(.MEM_BYTES(MEM_BYTES)) u_store (
      .clk     (clk),
      .we      (mem_we),
      .and_mode(mem_and),
      .waddr   (mem_waddr),
      .wdata   (mem_wdata),
      .raddr   (mem_raddr),
      .rdata   (mem_rdata)
   );
endmodule

// File: tb/spi_flash_responder_tb.sv
`timescale 1ns/1ps
module spi_flash_responder_tb;
   localparam int MEM = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sclk = 1'b0;
   logic spi_cs_n = 1'b1;
   logic spi_mosi = 1'b0;
   logic spi_miso;

   always #2.5 clk = ~clk;

   spi_flash_responder #(.BUSY_CYCLES(1000)) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .spi_sclk(spi_sclk),
      .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi),
      .spi_miso(spi_miso)
   );

   int         checks = 0;
   int         errs = 0;
   logic [7:0] txb [64];
   logic [7:0] rxb [64];
   logic [7:0] pbuf [16];
   logic [7:0] mdl_mem [MEM];
   logic       mdl_wel = 1'b0;
   logic       mdl_ewsr = 1'b0;
   logic [3:0] mdl_prot = 4'hF;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%02h exp=%02h", req, act, exp);
      end
   endtask

   task automatic run_frame(input int n);
      spi_cs_n = 1'b0;
      repeat (6) @(negedge clk);
      for (int b = 0; b < n; b++) begin
         logic [7:0] r;
         for (int i = 7; i >= 0; i--) begin
            spi_mosi = txb[b][i];
            repeat (6) @(negedge clk);
            r[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (6) @(negedge clk);
            spi_sclk = 1'b0;
         end
         rxb[b] = r;
      end
      repeat (6) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic op1(input logic [7:0] op);
      txb[0] = op;
      run_frame(1);
   endtask

   task automatic do_wren();
      op1(8'h06); mdl_wel = 1'b1; mdl_ewsr = 1'b0;
   endtask

   task automatic do_wrdi();
      op1(8'h04); mdl_wel = 1'b0; mdl_ewsr = 1'b0;
   endtask

   task automatic do_ewsr();
      op1(8'h50); mdl_ewsr = 1'b1;
   endtask

   task automatic do_wrsr(input logic [7:0] v);
      txb[0] = 8'h01; txb[1] = v;
      run_frame(2);
      if (mdl_wel || mdl_ewsr) begin
         mdl_prot = v[5:2];
         mdl_wel  = 1'b0;
      end
      mdl_ewsr = 1'b0;
   endtask

   task automatic do_pgm(input int addr, input int n);
      txb[0] = 8'h02;
      txb[1] = 8'(addr >> 16); txb[2] = 8'(addr >> 8); txb[3] = 8'(addr);
      for (int i = 0; i < n; i++) txb[4+i] = pbuf[i];
      run_frame(4 + n);
      if (mdl_wel && mdl_prot == 4'h0) begin
         for (int i = 0; i < n; i++) begin
            int a;
            a = (addr & 32'hF00) | ((addr + i) & 32'hFF);
            mdl_mem[a] = mdl_mem[a] & pbuf[i];
         end
      end
      mdl_wel = 1'b0; mdl_ewsr = 1'b0;
   endtask

   task automatic do_erase(input int addr);
      txb[0] = 8'h20;
      txb[1] = 8'(addr >> 16); txb[2] = 8'(addr >> 8); txb[3] = 8'(addr);
      run_frame(4);
      if (mdl_wel && mdl_prot == 4'h0)
         for (int i = 0; i < MEM; i++) mdl_mem[i] = 8'hFF;
      mdl_wel = 1'b0; mdl_ewsr = 1'b0;
   endtask

   task automatic rdsr_chk(input string req, input logic exp_busy);
      txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00;
      run_frame(3);
      chk(req, rxb[1], {2'b00, mdl_prot, mdl_wel, exp_busy});
      chk(req, rxb[2], {2'b00, mdl_prot, mdl_wel, exp_busy});
      mdl_ewsr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int addr, input int n, input bit fast);
      int hdr;
      hdr = fast ? 5 : 4;
      txb[0] = fast ? 8'h0B : 8'h03;
      txb[1] = 8'(addr >> 16); txb[2] = 8'(addr >> 8); txb[3] = 8'(addr);
      txb[4] = 8'h00;
      for (int i = 0; i < n; i++) txb[hdr+i] = 8'h00;
      run_frame(hdr + n);
      for (int i = 0; i < n; i++) chk(req, rxb[hdr+i], mdl_mem[(addr + i) % MEM]);
      mdl_ewsr = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int polls;
      polls = 0;
      do begin
         txb[0] = 8'h05; txb[1] = 8'h00;
         run_frame(2);
         polls++;
      end while (rxb[1][0] && polls < 200);
      mdl_ewsr = 1'b0;
      chk(req, {7'd0, rxb[1][0]}, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog R1 act=timeout exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < MEM; i++) mdl_mem[i] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 miso idle", {7'd0, spi_miso}, 8'h00);

      // R12: status during the power-up fill shows busy
      rdsr_chk("R12 busy during fill", 1'b1);
      repeat (5000) @(negedge clk);
      rdsr_chk("R2 reset status", 1'b0);
      rd_chk("R12 erased after reset", 32'h000100, 3, 1'b0);

      // R7: identity bytes then zero
      txb[0] = 8'h9F;
      for (int i = 1; i < 5; i++) txb[i] = 8'h00;
      run_frame(5);
      chk("R7 id0", rxb[1], 8'hA5);
      chk("R7 id1", rxb[2], 8'h40);
      chk("R7 id2", rxb[3], 8'h0C);
      chk("R7 tail", rxb[4], 8'h00);

      // R3: latch set and clear
      do_wren();
      rdsr_chk("R3 wren", 1'b0);
      do_wrdi();
      rdsr_chk("R3 wrdi", 1'b0);

      // R4: locked array ignores program
      do_wren();
      pbuf[0] = 8'h00;
      do_pgm(32'h000010, 1);
      rdsr_chk("R4 locked pgm status", 1'b0);
      rd_chk("R4 locked pgm data", 32'h000010, 1, 1'b0);

      // R4: status write without enable is ignored
      do_wrsr(8'h00);
      rdsr_chk("R4 wrsr no enable", 1'b0);
      // R4: unlock through the status-write enable opcode
      do_ewsr();
      do_wrsr(8'h00);
      rdsr_chk("R4 unlock via 50h", 1'b0);

      // R8, R9: program wraps in page, then busy with latch cleared
      do_wren();
      pbuf[0] = 8'hA5; pbuf[1] = 8'h5A; pbuf[2] = 8'h0F; pbuf[3] = 8'hF0;
      do_pgm(32'h0000FE, 4);
      rdsr_chk("R9 busy after pgm", 1'b1);
      op1(8'h06); // R11: ignored while busy
      rdsr_chk("R11 wren ignored", 1'b1);
      wait_idle("R9 busy ends");
      rdsr_chk("R11 latch still clear", 1'b0);
      rd_chk("R8 page wrap high", 32'h0000FE, 2, 1'b0);
      rd_chk("R8 page wrap low", 32'h000000, 2, 1'b0);

      // R8: program only clears bits
      do_wren();
      pbuf[0] = 8'hF3;
      do_pgm(32'h000000, 1);
      wait_idle("R9 busy ends");
      rd_chk("R8 and merge", 32'h000000, 1, 1'b0);

      // R8: program without latch
      pbuf[0] = 8'h00;
      do_pgm(32'h000200, 1);
      rd_chk("R8 no latch", 32'h000200, 1, 1'b0);

      // R6 and R5 wrap at array end
      rd_chk("R6 fast read", 32'h0000FE, 4, 1'b1);
      rd_chk("R5 array wrap", 32'h000FFF, 2, 1'b0);

      // R10: sector erase
      do_wren();
      do_erase(32'h000123);
      rdsr_chk("R10 busy in erase", 1'b1);
      wait_idle("R10 erase ends");
      rd_chk("R10 erased", 32'h0000FE, 4, 1'b0);

      // R4: relock through write enable, then program has no effect
      do_wren();
      do_wrsr(8'h3C);
      rdsr_chk("R4 relock", 1'b0);
      do_wren();
      pbuf[0] = 8'h00;
      do_pgm(32'h000300, 1);
      rd_chk("R4 relocked pgm", 32'h000300, 1, 1'b0);
      // R4: unlock through write enable
      do_wren();
      do_wrsr(8'h00);
      rdsr_chk("R4 unlock via 06h", 1'b0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule